// File: doc/BRIEF.md
# Selectable Clock Divider Cell

This cell turns a set of reference clocks into one gated output clock. A switch bit chooses between a primary reference and a bank of alternate references. When the alternate bank is chosen, a select field picks one of its members. The chosen clock, called the source clock below, runs a divider that offers three settings: straight through at ratio 1, a table of even ratios, or a fixed divide-by-3 path. The fixed divide-by-3 path takes priority over the other two. An enable bit gates the result.

All control inputs are static configuration bits, such as the outputs of a register file. A ratio change is held back until the current output period ends, so no shortened pulse reaches the output. Two combinational status outputs are provided. One reports the division ratio that the control bits currently request. The other reports the index of the chosen source: 0 for the primary clock, and the alternate number plus one for an alternate. Switching between sources is not glitch-protected. The source may only change while the cell is held in reset.

Top module: `clkdiv_cell`

## Requirements
- R1: With `pllSwitch` = 0 the divider runs from `refClk`. With `pllSwitch` = 1 it runs from `altClk[pllSelect]`.
- R2: `parentIndex` is 0 when `pllSwitch` = 0, and `pllSelect` + 1 when `pllSwitch` = 1.
- R3: `ratioStatus` is 3 when `div3Switch` = 1. It is 1 when `div3Switch` = 0 and `divSwitch` = 0. When both switches are set for the table (`div3Switch` = 0, `divSwitch` = 1), codes 0..7 of `divSelect` give ratios 1, 2, 4, 6, 8, 12, 1, 1.
- R4: At an active ratio of 1 and with `enable` = 1, `clkOut` follows the source clock level.
- R5: At an active even ratio N, the first source rising edge of each period starts it. `clkOut` is then high for N/2 source cycles and low for N/2 source cycles.
- R6: At the divide-by-3 setting, each 3-cycle period is high for 1 source cycle and low for 2. This holds whatever `divSwitch` and `divSelect` hold.
- R7: A change of the requested ratio becomes active only at the first source rising edge after the current period has completed.
- R8: With `enable` = 0, `clkOut` is low.
- R9: While `rstN` is low, `clkOut` is low and the active ratio is 1. At the first source rising edge after release, the requested ratio is loaded and a new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Primary reference clock |
| altClk | input | NUM_ALT | Alternate reference clocks |
| rstN | input | 1 | Asynchronous active-low reset |
| pllSwitch | input | 1 | 0 selects refClk, 1 selects an alternate |
| pllSelect | input | SEL_W | Alternate clock number |
| divSwitch | input | 1 | 0 bypasses the ratio table, 1 uses it |
| divSelect | input | 3 | Ratio table code |
| div3Switch | input | 1 | 1 forces the divide-by-3 path |
| enable | input | 1 | Output gate |
| clkOut | output | 1 | Divided and gated clock |
| ratioStatus | output | 4 | Ratio requested by the control bits |
| parentIndex | output | SEL_W+1 | Index of the chosen source clock |

## Verification
The assertions sample on the selected source clock. They take for granted that every control bit is stable around that clock's rising edges. They also take for granted that the source-selection bits change only while reset is held, because the clock mux itself offers no protection. The stimulus follows both rules. It changes control bits one time unit after a falling edge of the selected clock. It makes every source switch with `rstN` low, then releases reset away from any edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int RATIO_W = 4;
  localparam int DSEL_W  = 3;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic               bypass;
    logic               startHigh;
  } cfg_t;

  function automatic logic [RATIO_W-1:0] ratioOf(
    input logic              d3,
    input logic              dsw,
    input logic [DSEL_W-1:0] code
  );
    logic [RATIO_W-1:0] r;
    if (d3) begin
      r = RATIO_W'(3);
    end else if (!dsw) begin
      r = RATIO_W'(1);
    end else begin
      case (code)
        3'd0:    r = RATIO_W'(1);
        3'd1:    r = RATIO_W'(2);
        3'd2:    r = RATIO_W'(4);
        3'd3:    r = RATIO_W'(6);
        3'd4:    r = RATIO_W'(8);
        3'd5:    r = RATIO_W'(12);
        default: r = RATIO_W'(1);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_srcmux.sv
module clkdiv_srcmux #(
  parameter int NUM_ALT = 8,
  parameter int SEL_W   = (NUM_ALT > 1) ? $clog2(NUM_ALT) : 1
) (
  input  logic               refClk,
  input  logic [NUM_ALT-1:0] altClk,
  input  logic               pllSwitch,
  input  logic [SEL_W-1:0]   pllSelect,
  output logic               srcClk,
  output logic [SEL_W:0]     parentIndex
);

  logic selValid;
  logic altPick;

  assign selValid = ({1'b0, pllSelect} < (SEL_W+1)'(NUM_ALT));

  always_comb begin
    altPick = altClk[0];
    for (int i = 0; i < NUM_ALT; i++) begin
      if (selValid && ({1'b0, pllSelect} == (SEL_W+1)'(i))) begin
        altPick = altClk[i];
      end
    end
  end

  assign srcClk      = pllSwitch ? altPick : refClk;
  assign parentIndex = pllSwitch ? ({1'b0, pllSelect} + (SEL_W+1)'(1)) : '0;

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic              srcClk,
  input  logic              rstN,
  input  logic              div3Switch,
  input  logic              divSwitch,
  input  logic [DSEL_W-1:0] divSelect,
  input  logic              wrap,
  output cfg_t              cfg,
  output logic [RATIO_W-1:0] ratioStatus
);

  logic [RATIO_W-1:0] pending;
  logic [RATIO_W-1:0] activeRatio;

  assign pending     = ratioOf(div3Switch, divSwitch, divSelect);
  assign ratioStatus = pending;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      activeRatio <= RATIO_W'(1);
    end else if (wrap) begin
      activeRatio <= pending;
    end
  end

  always_comb begin
    cfg.ratio     = activeRatio;
    cfg.half      = activeRatio >> 1;
    cfg.bypass    = (activeRatio == RATIO_W'(1));
    cfg.startHigh = (pending > RATIO_W'(1));
  end

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               enable,
  input  cfg_t               cfg,
  output logic               wrap,
  output logic [RATIO_W-1:0] phase,
  output logic               divOut,
  output logic               clkOut
);

  logic [RATIO_W-1:0] phaseNext;
  logic               divNext;

  assign wrap = (phase == (cfg.ratio - RATIO_W'(1)));

  always_comb begin
    if (wrap) begin
      phaseNext = '0;
      divNext   = cfg.startHigh;
    end else begin
      phaseNext = phase + RATIO_W'(1);
      divNext   = (phaseNext < cfg.half);
    end
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      divOut <= 1'b0;
    end else begin
      phase  <= phaseNext;
      divOut <= divNext;
    end
  end

  assign clkOut = rstN & enable & (cfg.bypass ? srcClk : divOut);

endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
  import clkdiv_pkg::*;
#(
  parameter int NUM_ALT = 8,
  parameter int SEL_W   = (NUM_ALT > 1) ? $clog2(NUM_ALT) : 1
) (
  input  logic               refClk,
  input  logic [NUM_ALT-1:0] altClk,
  input  logic               rstN,
  input  logic               pllSwitch,
  input  logic [SEL_W-1:0]   pllSelect,
  input  logic               divSwitch,
  input  logic [DSEL_W-1:0]  divSelect,
  input  logic               div3Switch,
  input  logic               enable,
  output logic               clkOut,
  output logic [RATIO_W-1:0] ratioStatus,
  output logic [SEL_W:0]     parentIndex
);

  logic               srcClk;
  logic               wrap;
  logic [RATIO_W-1:0] phase;
  logic               divOut;
  logic [RATIO_W-1:0] activeRatio;
  cfg_t               cfg;

  clkdiv_srcmux #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) i_srcmux (
    .refClk      (refClk),
    .altClk      (altClk),
    .pllSwitch   (pllSwitch),
    .pllSelect   (pllSelect),
    .srcClk      (srcClk),
    .parentIndex (parentIndex)
  );

  clkdiv_ctrl i_ctrl (
    .srcClk      (srcClk),
    .rstN        (rstN),
    .div3Switch  (div3Switch),
    .divSwitch   (divSwitch),
    .divSelect   (divSelect),
    .wrap        (wrap),
    .cfg         (cfg),
    .ratioStatus (ratioStatus)
  );

  clkdiv_datapath i_datapath (
    .srcClk (srcClk),
    .rstN   (rstN),
    .enable (enable),
    .cfg    (cfg),
    .wrap   (wrap),
    .phase  (phase),
    .divOut (divOut),
    .clkOut (clkOut)
  );

  assign activeRatio = cfg.ratio;

endmodule

// File: rtl/clkdiv_cell_checker.sv
module clkdiv_cell_checker
  import clkdiv_pkg::*;
#(
  parameter int NUM_ALT = 8,
  parameter int SEL_W   = 3
) (
  input logic               srcClk,
  input logic               rstN,
  input logic               pllSwitch,
  input logic               wrap,
  input logic [RATIO_W-1:0] phase,
  input logic               divOut,
  input logic [RATIO_W-1:0] activeRatio,
  input logic [RATIO_W-1:0] ratioStatus,
  input logic [SEL_W:0]     parentIndex
);

  AST_PHASE_BOUND: assert property (@(posedge srcClk) disable iff (!rstN)
    phase < activeRatio); // R5

  AST_EVEN_LOW_HALF: assert property (@(posedge srcClk) disable iff (!rstN)
    (activeRatio > RATIO_W'(1) && activeRatio != RATIO_W'(3) &&
     phase == (activeRatio >> 1)) |-> !divOut); // R5

  AST_DIV3_SINGLE_HIGH: assert property (@(posedge srcClk) disable iff (!rstN)
    (activeRatio == RATIO_W'(3) && divOut) |=> !divOut); // R6

  AST_RATIO_HOLD: assert property (@(posedge srcClk) disable iff (!rstN)
    !wrap |=> $stable(activeRatio)); // R7

  AST_RATIO_LOAD: assert property (@(posedge srcClk) disable iff (!rstN)
    wrap |=> (activeRatio == $past(ratioStatus))); // R7

  always_comb begin
    AST_PARENT_RANGE: assert (parentIndex <= (SEL_W+1)'(NUM_ALT)); // R2
    AST_PARENT_ZERO: assert (pllSwitch == (parentIndex != '0)); // R2
  end

endmodule

bind clkdiv_cell clkdiv_cell_checker #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) i_checker (
  .srcClk      (srcClk),
  .rstN        (rstN),
  .pllSwitch   (pllSwitch),
  .wrap        (wrap),
  .phase       (phase),
  .divOut      (divOut),
  .activeRatio (activeRatio),
  .ratioStatus (ratioStatus),
  .parentIndex (parentIndex)
);

// File: tb/test_clkdiv_cell.sv
module test_clkdiv_cell;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ALT    = 8;
  localparam int SEL_W      = 3;

  logic               refClk = 1'b0;
  logic [NUM_ALT-1:0] altClk = '0;
  logic               rstN = 1'b0;
  logic               pllSwitch = 1'b0;
  logic [SEL_W-1:0]   pllSelect = '0;
  logic               divSwitch = 1'b0;
  logic [2:0]         divSelect = '0;
  logic               div3Switch = 1'b0;
  logic               enable = 1'b1;
  logic               clkOut;
  logic [3:0]         ratioStatus;
  logic [SEL_W:0]     parentIndex;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R9";
  int    tick = 0;

  clkdiv_cell #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) i_clkdiv_cell (
    .refClk      (refClk),
    .altClk      (altClk),
    .rstN        (rstN),
    .pllSwitch   (pllSwitch),
    .pllSelect   (pllSelect),
    .divSwitch   (divSwitch),
    .divSelect   (divSelect),
    .div3Switch  (div3Switch),
    .enable      (enable),
    .clkOut      (clkOut),
    .ratioStatus (ratioStatus),
    .parentIndex (parentIndex)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  // alternate clock i has a half period of i+3 time units
  always #1 begin
    tick++;
    for (int i = 0; i < NUM_ALT; i++) altClk[i] = ((tick / (i + 3)) % 2) == 1;
  end

  // R1: the clock the divider should be running from
  logic benchSel;
  assign benchSel = pllSwitch ? altClk[pllSelect] : refClk;

  // R3: requested ratio
  function automatic int expRatio(bit d3, bit dsw, int code);
    if (d3) return 3;
    if (!dsw) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 12;
      default: return 1;
    endcase
  endfunction

  // behavioural model of the divided waveform
  int mPhase = 0;
  int mRatio = 1;
  bit mOut   = 0;

  always @(posedge benchSel or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mRatio = 1; mOut = 0;
    end else begin
      if (mPhase == mRatio - 1) begin
        mRatio = expRatio(div3Switch, divSwitch, divSelect);
        mPhase = 0;
      end else begin
        mPhase++;
      end
      mOut = (mRatio > 1) && (mPhase < mRatio / 2);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareOut();
    bit exp;
    if (!rstN) exp = 0;
    else if (!enable) exp = 0;
    else if (mRatio == 1) exp = benchSel;
    else exp = mOut;
    check(curReq, "clkOut", clkOut, exp);
  endtask

  always @(posedge benchSel) begin #1; compareOut(); end
  always @(negedge benchSel) begin #1; compareOut(); end

  task automatic syncNeg();
    @(negedge benchSel);
    #1;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge benchSel);
    syncNeg();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R9 reset state and R3/R2 status sweeps while held in reset
    curReq = "R9";
    #(CLK_PERIOD * 3 + 2);
    check("R9", "clkOut in reset", clkOut, 0);
    for (int d3 = 0; d3 < 2; d3++)
      for (int dsw = 0; dsw < 2; dsw++)
        for (int c = 0; c < 8; c++) begin
          div3Switch = d3[0]; divSwitch = dsw[0]; divSelect = c[2:0];
          #1;
          check("R3", "ratioStatus", ratioStatus, expRatio(d3[0], dsw[0], c));
        end
    pllSwitch = 0; #1;
    check("R2", "parentIndex primary", parentIndex, 0);
    for (int s = 0; s < NUM_ALT; s++) begin
      pllSwitch = 1; pllSelect = s[SEL_W-1:0]; #1;
      check("R2", "parentIndex alternate", parentIndex, s + 1);
    end
    pllSwitch = 0; pllSelect = 0;
    div3Switch = 0; divSwitch = 0; divSelect = 0;
    syncNeg();
    rstN = 1;

    // R4 bypass on the primary clock
    curReq = "R4";
    run(20);

    // R5 even ratios, switched mid-period (R7)
    divSwitch = 1;
    for (int c = 1; c <= 5; c++) begin
      curReq = "R7"; divSelect = c[2:0];
      run(3);
      curReq = "R5";
      run(40);
    end
    curReq = "R3"; divSelect = 6; run(15);
    divSelect = 7; run(15);
    curReq = "R7"; divSelect = 5; run(5);
    divSelect = 1; run(30);

    // R6 divide-by-3 overrides the table and the bypass
    curReq = "R6"; div3Switch = 1; divSelect = 5; run(30);
    divSwitch = 0; run(30);
    div3Switch = 0; divSwitch = 1; divSelect = 3; curReq = "R7"; run(30);

    // R8 gate
    curReq = "R8"; enable = 0; run(25);
    check("R8", "clkOut gated", clkOut, 0);
    enable = 1; curReq = "R5"; run(20);

    // R1 alternate sources, switched under reset
    curReq = "R9"; rstN = 0; run(3);
    check("R9", "clkOut reset mid-run", clkOut, 0);
    pllSwitch = 1; pllSelect = 3; divSwitch = 0; #20;
    syncNeg(); rstN = 1;
    curReq = "R1"; run(20);
    divSwitch = 1; divSelect = 2; run(30);
    curReq = "R9"; rstN = 0; run(3);
    pllSelect = 7; divSelect = 4; #30;
    syncNeg(); rstN = 1;
    curReq = "R1"; run(40);
    div3Switch = 1; curReq = "R6"; run(20);

    summary();
    $finish;
  end

endmodule